// File: doc/BRIEF.md
# ATM Cell Boundary Locator

This block watches a serial receive stream, one bit per enabled clock, and finds where ATM cells begin by using the header check byte. It keeps a 40-bit window of the most recent bits. The oldest 32 bits are treated as a header candidate and the newest 8 bits as that header's check byte. While unlocked, the block tests every bit position. After the first hit, it tests only once per cell period. It declares lock after a run of good checks and gives it up after a run of bad ones.

Downstream logic uses the state output to decide when to trust the stream. A one-cycle strobe marks each header end that the block accepts as a boundary, and a position counter gives the bit offset from that boundary. The block only detects errors. It does not descramble, buffer or correct anything.

Top module: `cell_delin`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, state_o is 0 (HUNT), cell_start_o and hdr_ok_o are 0, and bit_pos_o is 0.
- R2: A window is valid when its newest 8 bits equal the check value of its oldest 32 bits. The oldest bit received is the MSB of the first header byte. The check value is the CRC-8 of the 32 bits, MSB first, with generator x^8+x^2+x+1 (0x07) and initial value 0, XORed with 0x55. hdr_ok_o pulses for one cycle after each evaluation point at which the window is valid.
- R3: In HUNT (state_o=0) every enabled bit is an evaluation point. On the first valid window the state becomes PRESYNC (state_o=1). In the following cycle cell_start_o pulses and bit_pos_o reads 0.
- R4: Outside HUNT, bit_pos_o advances by one on each enabled bit and wraps to 0 after CELL_BITS-1. The only evaluation point is the enabled bit that takes bit_pos_o from CELL_BITS-1 back to 0. A valid window at any other bit has no effect on state_o or hdr_ok_o.
- R5: An invalid window at a PRESYNC evaluation point returns the block to HUNT, and cell_start_o does not pulse for that point.
- R6: ENTER_CNT consecutive valid evaluation points in PRESYNC, counted after the hunt hit, move the state to SYNC (state_o=2).
- R7: In SYNC, LOSS_CNT consecutive invalid evaluation points return the block to HUNT. After fewer misses the block stays in SYNC and cell_start_o still pulses with hdr_ok_o low.
- R8: A valid evaluation point in SYNC clears the consecutive-miss count.
- R9: A cycle with bit_en_i low leaves state_o and bit_pos_o unchanged and ends any strobe on cell_start_o and hdr_ok_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial receive bit |
| bit_en_i | input | 1 | Qualifies bit_i for this cycle |
| state_o | output | 2 | Lock state: 0 HUNT, 1 PRESYNC, 2 SYNC |
| cell_start_o | output | 1 | One-cycle strobe at an accepted boundary |
| hdr_ok_o | output | 1 | One-cycle strobe when a checked header is valid |
| bit_pos_o | output | $clog2(CELL_BITS) | Bit offset from the last boundary |

## Verification
The bench builds the block with CELL_BITS=48, ENTER_CNT=2 and LOSS_CNT=3. With these values every entry, early-drop, lock and loss sequence fits in a handful of cells. Sweeping all 128 patterns of good and bad headers over seven cells, with varying lead-in offsets and random idle cycles, therefore covers every order of hits and misses the counters can see. Random payload also produces false hunt hits, which exercises the PRESYNC drop path on real data.

// File: rtl/cd_pkg.sv
package cd_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } cd_state_e;

  // CRC-8, poly 0x07, init 0, MSB first
  function automatic logic [7:0] hec_calc(input logic [31:0] hdr);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ hdr[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction
endpackage

// File: rtl/cd_window.sv
module cd_window #(
  parameter logic [7:0] COSET = 8'h55
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_en_i,
  output logic match_o
);
  import cd_pkg::*;
  localparam int HDR_BITS = 32;
  localparam int HEC_BITS = 8;
  localparam int WIN      = HDR_BITS + HEC_BITS;

  logic [WIN-1:0] win_q, win_d;

  // window as it stands once the current bit is taken
  assign win_d   = {win_q[WIN-2:0], bit_i};
  assign match_o = (hec_calc(win_d[WIN-1:HEC_BITS]) ^ COSET) == win_d[HEC_BITS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       win_q <= '0;
    else if (bit_en_i) win_q <= win_d;
  end
endmodule

// File: rtl/cd_fsm.sv
module cd_fsm #(
  parameter int CELL_BITS = 424,
  parameter int ENTER_CNT = 6,
  parameter int LOSS_CNT  = 7,
  localparam int PW = $clog2(CELL_BITS),
  localparam int GW = $clog2(ENTER_CNT + 1),
  localparam int MW = $clog2(LOSS_CNT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic          match_i,
  output cd_pkg::cd_state_e state_o,
  output logic          cell_start_o,
  output logic          hdr_ok_o,
  output logic [PW-1:0] bit_pos_o
);
  import cd_pkg::*;

  cd_state_e     state_q, state_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [GW-1:0] good_q, good_d;
  logic [MW-1:0] miss_q, miss_d;
  logic          cs_q, ok_q;
  logic          chk_pt;

  assign chk_pt = bit_en_i && (state_q == ST_HUNT || pos_q == PW'(CELL_BITS - 1));

  always_comb begin
    state_d = state_q;
    good_d  = good_q;
    miss_d  = miss_q;
    pos_d   = pos_q;
    if (bit_en_i) pos_d = (state_q == ST_HUNT || chk_pt) ? '0 : pos_q + 1'b1;
    if (chk_pt) begin
      unique case (state_q)
        ST_HUNT: if (match_i) begin
          state_d = ST_PRESYNC;
          good_d  = '0;
        end
        ST_PRESYNC: begin
          if (!match_i) begin
            state_d = ST_HUNT;
            good_d  = '0;
          end else if (good_q == GW'(ENTER_CNT - 1)) begin
            state_d = ST_SYNC;
            good_d  = '0;
            miss_d  = '0;
          end else begin
            good_d = good_q + 1'b1;
          end
        end
        ST_SYNC: begin
          if (match_i) miss_d = '0;
          else if (miss_q == MW'(LOSS_CNT - 1)) begin
            state_d = ST_HUNT;
            miss_d  = '0;
          end else miss_d = miss_q + 1'b1;
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      pos_q   <= '0;
      good_q  <= '0;
      miss_q  <= '0;
      cs_q    <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      good_q  <= good_d;
      miss_q  <= miss_d;
      cs_q    <= chk_pt && (state_d != ST_HUNT);
      ok_q    <= chk_pt && match_i;
    end
  end

  assign state_o      = state_q;
  assign cell_start_o = cs_q;
  assign hdr_ok_o     = ok_q;
  assign bit_pos_o    = pos_q;

  // R3
  boundary_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_start_o |-> bit_pos_o == '0);
  // R4
  mid_cell_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && state_q != ST_HUNT && pos_q != PW'(CELL_BITS - 1)) |=> state_q == $past(state_q));
  // R5
  presync_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_pt && state_q == ST_PRESYNC && !match_i) |=> (state_q == ST_HUNT && !cell_start_o));
  // R7
  sync_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_pt && state_q == ST_SYNC && !match_i && miss_q == MW'(LOSS_CNT - 1)) |=> state_q == ST_HUNT);
  // R8
  miss_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_pt && state_q == ST_SYNC && match_i) |=> (miss_q == '0 && state_q == ST_SYNC));
  // R9
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(state_q) && $stable(pos_q) && !cell_start_o && !hdr_ok_o));
endmodule

// File: rtl/cell_delin.sv
module cell_delin #(
  parameter int CELL_BITS = 424,
  parameter int ENTER_CNT = 6,
  parameter int LOSS_CNT  = 7,
  localparam int PW = $clog2(CELL_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_i,
  input  logic          bit_en_i,
  output logic [1:0]    state_o,
  output logic          cell_start_o,
  output logic          hdr_ok_o,
  output logic [PW-1:0] bit_pos_o
);
  import cd_pkg::*;

  logic      match;
  cd_state_e st;

  cd_window #(.COSET(8'h55)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_i    (bit_i),
    .bit_en_i (bit_en_i),
    .match_o  (match)
  );

  cd_fsm #(
    .CELL_BITS (CELL_BITS),
    .ENTER_CNT (ENTER_CNT),
    .LOSS_CNT  (LOSS_CNT)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_en_i     (bit_en_i),
    .match_i      (match),
    .state_o      (st),
    .cell_start_o (cell_start_o),
    .hdr_ok_o     (hdr_ok_o),
    .bit_pos_o    (bit_pos_o)
  );

  assign state_o = st;
endmodule

// File: tb/cell_delin_tb_top.sv
`timescale 1ns/1ps
module cell_delin_tb_top;
  localparam int CB = 48;
  localparam int EN = 2;
  localparam int LS = 3;
  localparam int PW = $clog2(CB);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_i = 1'b0;
  logic bit_en_i = 1'b0;
  logic [1:0] state_o;
  logic cell_start_o, hdr_ok_o;
  logic [PW-1:0] bit_pos_o;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  // reference model state
  int m_st, m_pos, m_good, m_miss;
  bit m_cs, m_ok;
  logic [39:0] m_win;

  always #2.5 clk = ~clk;

  cell_delin #(.CELL_BITS(CB), .ENTER_CNT(EN), .LOSS_CNT(LS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .bit_en_i(bit_en_i),
    .state_o(state_o), .cell_start_o(cell_start_o), .hdr_ok_o(hdr_ok_o),
    .bit_pos_o(bit_pos_o)
  );

  // remainder of hdr*x^8 mod x^8+x^2+x+1, by long division
  function automatic logic [7:0] ref_hec(input logic [31:0] hdr);
    logic [39:0] v;
    v = {hdr, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (v[i]) v[i -: 9] = v[i -: 9] ^ 9'h107;
    return v[7:0] ^ 8'h55;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 R5 R6 R7 R8 state", int'(state_o), m_st);
    chk("R4 R9 bit_pos", int'(bit_pos_o), m_pos);
    chk("R3 R7 cell_start", int'(cell_start_o), int'(m_cs));
    chk("R2 hdr_ok", int'(hdr_ok_o), int'(m_ok));
  endtask

  task automatic model_reset();
    m_st = 0; m_pos = 0; m_good = 0; m_miss = 0;
    m_cs = 0; m_ok = 0; m_win = '0;
  endtask

  task automatic model_step(input bit en, input bit b);
    bit m, cp;
    int nst;
    m_cs = 0; m_ok = 0;
    if (!en) return;
    m_win = {m_win[38:0], b};
    m = (ref_hec(m_win[39:8]) == m_win[7:0]);
    cp = (m_st == 0) || (m_pos == CB - 1);
    nst = m_st;
    if (cp) begin
      if (m_st == 0) begin
        if (m) begin nst = 1; m_good = 0; end
      end else if (m_st == 1) begin
        if (!m) begin nst = 0; m_good = 0; end
        else if (m_good == EN - 1) begin nst = 2; m_good = 0; m_miss = 0; end
        else m_good++;
      end else begin
        if (m) m_miss = 0;
        else if (m_miss == LS - 1) begin nst = 0; m_miss = 0; end
        else m_miss++;
      end
      m_cs = (nst != 0);
      m_ok = m;
      m_pos = 0;
    end else begin
      m_pos = (m_st == 0) ? 0 : m_pos + 1;
    end
    m_st = nst;
  endtask

  // one clock: check at negedge, drive, advance model
  task automatic cyc(input bit en, input bit b);
    @(negedge clk);
    compare_all();
    bit_en_i = en;
    bit_i    = b;
    model_step(en, b);
  endtask

  task automatic send_bit(input bit b);
    if ($urandom_range(0, 4) == 0) cyc(1'b0, 1'b0); // R9 idle gap
    cyc(1'b1, b);
  endtask

  task automatic send_cell(input bit good, input int c);
    logic [31:0] h;
    logic [7:0]  e;
    h = $urandom;
    e = ref_hec(h);
    if (!good) e = e ^ (8'h01 << (c % 8));
    for (int i = 31; i >= 0; i--) send_bit(h[i]);
    for (int i = 7; i >= 0; i--) send_bit(e[i]);
    for (int i = 0; i < CB - 40; i++) send_bit(1'($urandom));
  endtask

  initial begin
    model_reset();
    for (int p = 0; p < 128; p++) begin
      @(negedge clk);
      rst_ni = 1'b0; bit_en_i = 1'b0;
      model_reset();
      repeat (2) begin
        @(negedge clk);
        chk("R1 reset state", int'(state_o), 0);
        chk("R1 reset pos", int'(bit_pos_o), 0);
        chk("R1 reset strobes", int'(cell_start_o | hdr_ok_o), 0);
      end
      rst_ni = 1'b1;
      for (int i = 0; i < p % 13; i++) send_bit(1'($urandom));
      for (int c = 0; c < 10; c++) send_cell((c < 7) ? ~p[c] : 1'b1, c);
      cyc(1'b0, 1'b0);
    end
    @(negedge clk);
    compare_all();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #900000;
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule